// File: doc/BRIEF.md
# Indexed Performance Counter Bank

This block is a bank of hardware event counters for a processor core. Software reaches it through one small register window driven by a simple write strobe and a combinational read path. A counter-select register picks one counter. The configuration, count and snapshot registers then act on that counter alone. Each counter holds a condition code that chooses one bit of the incoming condition-strobe vector. Code zero never matches, so writing zero to a counter's configuration stops that counter. A run bit in the control register starts or halts every counter together.

Counters are `32 + 16*SIZE_SEL` bits wide and wrap silently; no interrupt is raised. Software can write the low and high count words separately to preset or clear a counter. Reading a counter that is still running is made safe by a snapshot. Setting the snapshot bit in a control write copies the whole selected count into a 64-bit snapshot pair at one clock edge, and software reads that pair at leisure.

A read-only capability word describes the unit. A second select register picks a countable condition, and two name words return that condition's 8-character ASCII label. The label is the text `EVNT` followed by the condition number as four upper-case hex digits.

Top module: `perf_ctr_bank`

## Requirements
- R1: Configuration and count writes change only the counter named by the counter-select register (address 0, bits 7:0). Configuration and count reads return that counter's values.
- R2: The control register's bit 0 is the run bit. While it is 0, no counter changes except through a count write.
- R3: A control write (address 1) with bit 1 set loads the selected counter's full value, as it was before that clock edge, into the snapshot pair. The low 32 bits read at address 5 and the upper bits at address 6. The pair then holds its value until the next snapshot.
- R4: Control bit 1 always reads back 0. Control bits 31:16 keep whatever was last written to them, and bits 15:2 read as 0.
- R5: A counter whose configuration code (address 2) is 0 never increments, whatever the strobe inputs do.
- R6: With the run bit set, a counter with code c (c non-zero) adds exactly one on each clock in which strobe bit c is high. The other strobe bits have no effect on it.
- R7: A write to address 3 replaces only bits 31:0 of the selected count, and a write to address 4 replaces only the bits above 31. An increment in the same cycle as a count write is lost, and the written value stands.
- R8: A counter holding all ones wraps to zero on its next increment.
- R9: The capability word (address 7) reads bit 0 = 1, bits 15:8 = NUM_CTRS, bits 23:16 = SIZE_SEL and bits 31:24 = NUM_CONDS. All other bits read 0.
- R10: The condition-select register is at address 8, bits 7:0. Address 9 returns characters 0..3 of the selected condition's name and address 10 returns characters 4..7, with the first character of each word in bits 7:0. When the selection is NUM_CONDS or greater, both words read 0.
- R11: When the counter select is NUM_CTRS or greater, configuration and count writes change no counter, and configuration, count and snapshot-capture sources all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_strobe | input | NUM_CONDS | One strobe per countable condition; bit 0 is never counted |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
The bound checker watches every counter on every cycle. It confirms that a halted counter or a code-zero counter holds its value and that a running, matching counter steps by exactly one. It also checks that a count write lands only in its own half, that a snapshot captures the pre-edge value and then holds, and that the snapshot bit never reads back as 1. Other properties depend on the register sequence as a whole: which counter a select value reaches, the atomicity of a snapshot taken across a carry out of the low word, the wrap to zero, and the decoded capability and name words. Only the bench's scenarios show these. The bench sweeps every counter against every code and every strobe bit.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int ADDR_W = 4;
  localparam int SEL_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTR_SEL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd1;
  localparam logic [ADDR_W-1:0] A_CFG      = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd4;
  localparam logic [ADDR_W-1:0] A_SNAP_LO  = 4'd5;
  localparam logic [ADDR_W-1:0] A_SNAP_HI  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAPS     = 4'd7;
  localparam logic [ADDR_W-1:0] A_COND_SEL = 4'd8;
  localparam logic [ADDR_W-1:0] A_NAME_LO  = 4'd9;
  localparam logic [ADDR_W-1:0] A_NAME_HI  = 4'd10;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SNAP_BIT = 1;

  function automatic int ctr_width(input int size_sel);
    return 32 + 16 * size_sel;
  endfunction

  function automatic logic [7:0] hex_char(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'd0, nib};
    return 8'h41 + {4'd0, nib} - 8'd10;
  endfunction

  // label "EVNT" + 4 hex digits, character 0 in bits 7:0
  function automatic logic [63:0] cond_label(input logic [15:0] k);
    logic [63:0] s;
    s[7:0]   = 8'h45;
    s[15:8]  = 8'h56;
    s[23:16] = 8'h4E;
    s[31:24] = 8'h54;
    s[39:32] = hex_char(k[15:12]);
    s[47:40] = hex_char(k[11:8]);
    s[55:48] = hex_char(k[7:4]);
    s[63:56] = hex_char(k[3:0]);
    return s;
  endfunction

endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CTR_W     = 48,
  parameter int NUM_CONDS = 8,
  localparam int COND_W   = (NUM_CONDS > 1) ? $clog2(NUM_CONDS) : 1,
  localparam int HI_W     = CTR_W - 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NUM_CONDS-1:0] cond_strobe,
  input  logic              cfg_we,
  input  logic [COND_W-1:0] cfg_wdata,
  input  logic              lo_we,
  input  logic [31:0]       lo_wdata,
  input  logic              hi_we,
  input  logic [HI_W-1:0]   hi_wdata,
  output logic [COND_W-1:0] cfg_q,
  output logic [CTR_W-1:0]  cnt_q,
  output logic              inc_o
);

  function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] v);
    return v + CTR_W'(1);
  endfunction

  logic cond_hit;

  always_comb begin
    cond_hit = 1'b0;
    if (cfg_q != '0 && int'(cfg_q) < NUM_CONDS) cond_hit = cond_strobe[cfg_q];
  end

  assign inc_o = run && cond_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (lo_we || hi_we) begin
      if (lo_we) cnt_q[31:0] <= lo_wdata;
      if (hi_we) cnt_q[CTR_W-1:32] <= hi_wdata;
    end else if (inc_o) begin
      cnt_q <= bump(cnt_q);
    end
  end

endmodule

// File: rtl/pcb_snap.sv
module pcb_snap #(
  parameter int CTR_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [CTR_W-1:0] value,
  output logic [63:0]      snap_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   snap_q <= '0;
    else if (cap) snap_q <= 64'(value);
  end

endmodule

// File: rtl/pcb_names.sv
module pcb_names #(
  parameter int NUM_CONDS = 8,
  parameter int SEL_W     = 8
) (
  input  logic [SEL_W-1:0] cond_sel,
  output logic [31:0]      name_lo,
  output logic [31:0]      name_hi
);
  import pcb_pkg::*;

  logic [63:0] label;

  always_comb begin
    label = '0;
    if (int'(cond_sel) < NUM_CONDS) label = cond_label(16'(cond_sel));
  end

  assign name_lo = label[31:0];
  assign name_hi = label[63:32];

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter int NUM_CTRS  = 4,
  parameter int SIZE_SEL  = 1,
  parameter int NUM_CONDS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CONDS-1:0] cond_strobe,
  input  logic                 reg_we,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata
);
  import pcb_pkg::*;

  localparam int CTR_W  = ctr_width(SIZE_SEL);
  localparam int HI_W   = CTR_W - 32;
  localparam int COND_W = (NUM_CONDS > 1) ? $clog2(NUM_CONDS) : 1;

  // register state
  logic [SEL_W-1:0] ctr_sel_q;
  logic [SEL_W-1:0] cond_sel_q;
  logic             run_q;
  logic [15:0]      ctrl_keep_q;

  // named internal events
  logic wr_ctr_sel, wr_ctrl, wr_cfg, wr_lo, wr_hi, wr_cond_sel;
  logic sel_ok;
  logic snap_cap;
  logic [NUM_CTRS-1:0] cfg_wr, lo_wr, hi_wr, cnt_wr, ctr_inc;
  logic [NUM_CTRS-1:0][CTR_W-1:0]  cnt_pk;
  logic [NUM_CTRS-1:0][COND_W-1:0] cfg_pk;
  logic [CTR_W-1:0]  sel_cnt;
  logic [COND_W-1:0] sel_cfg;
  logic [63:0]       snap_q;
  logic [31:0]       name_lo, name_hi;
  logic [31:0]       caps_word;

  assign wr_ctr_sel  = reg_we && reg_addr == A_CTR_SEL;
  assign wr_ctrl     = reg_we && reg_addr == A_CTRL;
  assign wr_cfg      = reg_we && reg_addr == A_CFG;
  assign wr_lo       = reg_we && reg_addr == A_CNT_LO;
  assign wr_hi       = reg_we && reg_addr == A_CNT_HI;
  assign wr_cond_sel = reg_we && reg_addr == A_COND_SEL;
  assign sel_ok      = int'(ctr_sel_q) < NUM_CTRS;
  assign snap_cap    = wr_ctrl && reg_wdata[CTRL_SNAP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_sel_q   <= '0;
      cond_sel_q  <= '0;
      run_q       <= 1'b0;
      ctrl_keep_q <= '0;
    end else begin
      if (wr_ctr_sel)  ctr_sel_q  <= reg_wdata[SEL_W-1:0];
      if (wr_cond_sel) cond_sel_q <= reg_wdata[SEL_W-1:0];
      if (wr_ctrl) begin
        run_q       <= reg_wdata[CTRL_RUN_BIT];
        ctrl_keep_q <= reg_wdata[31:16];
      end
    end
  end

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    logic hit_sel;
    assign hit_sel   = sel_ok && ctr_sel_q == SEL_W'(g);
    assign cfg_wr[g] = wr_cfg && hit_sel;
    assign lo_wr[g]  = wr_lo && hit_sel;
    assign hi_wr[g]  = wr_hi && hit_sel;
    assign cnt_wr[g] = lo_wr[g] || hi_wr[g];

    pcb_counter #(
      .CTR_W     (CTR_W),
      .NUM_CONDS (NUM_CONDS)
    ) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_q),
      .cond_strobe (cond_strobe),
      .cfg_we      (cfg_wr[g]),
      .cfg_wdata   (reg_wdata[COND_W-1:0]),
      .lo_we       (lo_wr[g]),
      .lo_wdata    (reg_wdata),
      .hi_we       (hi_wr[g]),
      .hi_wdata    (reg_wdata[HI_W-1:0]),
      .cfg_q       (cfg_pk[g]),
      .cnt_q       (cnt_pk[g]),
      .inc_o       (ctr_inc[g])
    );
  end

  always_comb begin
    sel_cnt = '0;
    sel_cfg = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (ctr_sel_q == SEL_W'(i)) begin
        sel_cnt = cnt_pk[i];
        sel_cfg = cfg_pk[i];
      end
    end
  end

  pcb_snap #(.CTR_W(CTR_W)) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (snap_cap),
    .value  (sel_cnt),
    .snap_q (snap_q)
  );

  pcb_names #(.NUM_CONDS(NUM_CONDS), .SEL_W(SEL_W)) u_names (
    .cond_sel (cond_sel_q),
    .name_lo  (name_lo),
    .name_hi  (name_hi)
  );

  assign caps_word = {8'(NUM_CONDS), 8'(SIZE_SEL), 8'(NUM_CTRS), 7'd0, 1'b1};

  always_comb begin
    unique case (reg_addr)
      A_CTR_SEL:  reg_rdata = 32'(ctr_sel_q);
      A_CTRL:     reg_rdata = {ctrl_keep_q, 15'd0, run_q};
      A_CFG:      reg_rdata = 32'(sel_cfg);
      A_CNT_LO:   reg_rdata = sel_cnt[31:0];
      A_CNT_HI:   reg_rdata = 32'(sel_cnt[CTR_W-1:32]);
      A_SNAP_LO:  reg_rdata = snap_q[31:0];
      A_SNAP_HI:  reg_rdata = snap_q[63:32];
      A_CAPS:     reg_rdata = caps_word;
      A_COND_SEL: reg_rdata = 32'(cond_sel_q);
      A_NAME_LO:  reg_rdata = name_lo;
      A_NAME_HI:  reg_rdata = name_hi;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int NUM_CTRS = 4,
  parameter int CTR_W    = 48,
  parameter int COND_W   = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           run_q,
  input logic [NUM_CTRS-1:0]            ctr_inc,
  input logic [NUM_CTRS-1:0]            cnt_wr,
  input logic [NUM_CTRS-1:0]            lo_wr,
  input logic [NUM_CTRS-1:0][CTR_W-1:0] cnt_pk,
  input logic [NUM_CTRS-1:0][COND_W-1:0] cfg_pk,
  input logic                           snap_cap,
  input logic [CTR_W-1:0]               sel_cnt,
  input logic [63:0]                    snap_q,
  input logic [3:0]                     reg_addr,
  input logic [31:0]                    reg_wdata,
  input logic [31:0]                    reg_rdata
);
  import pcb_pkg::*;

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_chk
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cnt_wr[g]) |=> $stable(cnt_pk[g])); // R2
    AST_CODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pk[g] == '0 && !cnt_wr[g]) |=> $stable(cnt_pk[g])); // R5
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_inc[g] && !cnt_wr[g]) |=> cnt_pk[g] == $past(cnt_pk[g]) + CTR_W'(1)); // R6
    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr[g] |=> cnt_pk[g][31:0] == $past(reg_wdata)); // R7
    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr[g] |=> cnt_pk[g][CTR_W-1:32] == $past(cnt_pk[g][CTR_W-1:32])); // R7
  end

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cap |=> snap_q == 64'($past(sel_cnt))); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cap |=> $stable(snap_q)); // R3
  AST_SNAP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> reg_rdata[CTRL_SNAP_BIT] == 1'b0); // R4

endmodule

bind perf_ctr_bank pcb_checker #(
  .NUM_CTRS (NUM_CTRS),
  .CTR_W    (CTR_W),
  .COND_W   (COND_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .ctr_inc   (ctr_inc),
  .cnt_wr    (cnt_wr),
  .lo_wr     (lo_wr),
  .cnt_pk    (cnt_pk),
  .cfg_pk    (cfg_pk),
  .snap_cap  (snap_cap),
  .sel_cnt   (sel_cnt),
  .snap_q    (snap_q),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata)
);

// File: tb/perf_ctr_bank_bench.sv
module perf_ctr_bank_bench;

  localparam int NCTR  = 4;
  localparam int NCOND = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCOND-1:0] cond_strobe = '0;
  logic             reg_we = 1'b0;
  logic [3:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perf_ctr_bank #(.NUM_CTRS(NCTR), .SIZE_SEL(1), .NUM_CONDS(NCOND)) u_perf_ctr_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond_strobe (cond_strobe),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [NCOND-1:0] v, input int n);
    @(negedge clk);
    cond_strobe = v;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cond_strobe = '0;
  endtask

  function automatic logic [31:0] name_word(input int k, input int half);
    string s;
    logic [31:0] w;
    s = $sformatf("EVNT%04X", k);
    for (int b = 0; b < 4; b++) w[8*b +: 8] = s[4*half + b];
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd(4'd1, v); check("R2 reset control", v, 32'h0);
    rd(4'd3, v); check("R1 reset count", v, 32'h0);
    rd(4'd5, v); check("R3 reset snapshot", v, 32'h0);

    // R9 capability word
    rd(4'd7, v); check("R9 caps", v, 32'h08010401);

    // R4 control readback
    wr(4'd1, 32'hABCD_0003);
    rd(4'd1, v); check("R4 control readback", v, 32'hABCD_0001);

    // R5 R6 sweep: every counter x every code x every strobe bit
    for (int i = 0; i < NCTR; i++) begin
      for (int c = 0; c < NCOND; c++) begin
        wr(4'd0, i);
        wr(4'd2, c);
        wr(4'd3, 0);
        wr(4'd4, 0);
        for (int b = 0; b < NCOND; b++) pulse(NCOND'(1) << b, b + 1);
        rd(4'd3, v);
        check($sformatf("R6 R5 ctr%0d code%0d", i, c), v, (c != 0) ? c + 1 : 0);
      end
      wr(4'd2, 0);
    end
    for (int i = 0; i < NCTR; i++) begin
      wr(4'd0, i); wr(4'd3, 32'h10 + i);
    end

    // R1 select isolation
    wr(4'd0, 2); wr(4'd3, 32'h55);
    wr(4'd0, 0); rd(4'd3, v); check("R1 other counter untouched", v, 32'h10);
    wr(4'd0, 2); rd(4'd3, v); check("R1 selected counter written", v, 32'h55);

    // R11 out-of-range select
    wr(4'd0, 9); wr(4'd3, 32'hDEAD); wr(4'd2, 3);
    rd(4'd3, v); check("R11 count reads zero", v, 0);
    rd(4'd2, v); check("R11 config reads zero", v, 0);
    for (int i = 0; i < NCTR; i++) begin
      wr(4'd0, i); rd(4'd3, v);
      check($sformatf("R11 ctr%0d untouched", i), v, (i == 2) ? 32'h55 : 32'h10 + i);
    end

    // R7 write wins over increment, halves independent
    wr(4'd0, 0); wr(4'd2, 2); wr(4'd3, 0); wr(4'd4, 7);
    @(negedge clk) cond_strobe = 8'h04;
    repeat (3) @(posedge clk);
    @(negedge clk) begin reg_addr = 4'd3; reg_wdata = 32'h100; reg_we = 1'b1; end
    @(negedge clk) begin reg_we = 1'b0; cond_strobe = '0; end
    rd(4'd3, v); check("R7 low write wins", v, 32'h100);
    rd(4'd4, v); check("R7 high untouched", v, 32'h7);
    wr(4'd4, 32'h12);
    rd(4'd3, v); check("R7 low untouched by high write", v, 32'h100);
    rd(4'd4, v); check("R7 high written", v, 32'h12);
    wr(4'd2, 0);

    // R3 atomic snapshot across a low-word carry
    wr(4'd0, 1); wr(4'd2, 5); wr(4'd4, 5); wr(4'd3, 32'hFFFF_FFFE);
    @(negedge clk) cond_strobe = 8'h20;
    repeat (3) @(posedge clk);
    @(negedge clk) begin reg_addr = 4'd1; reg_wdata = 32'h3; reg_we = 1'b1; end
    @(negedge clk) begin reg_we = 1'b0; cond_strobe = '0; end
    rd(4'd5, v); check("R3 snapshot low", v, 32'h1);
    rd(4'd6, v); check("R3 snapshot high", v, 32'h6);
    rd(4'd3, v); check("R3 count moved on low", v, 32'h2);
    rd(4'd1, v); check("R4 snap bit clear", v, 32'h1);
    pulse(8'h20, 4);
    rd(4'd5, v); check("R3 snapshot holds", v, 32'h1);

    // R8 wrap
    wr(4'd0, 3); wr(4'd2, 7); wr(4'd4, 32'hFFFF); wr(4'd3, 32'hFFFF_FFFF);
    pulse(8'h80, 2);
    rd(4'd3, v); check("R8 wrap low", v, 32'h1);
    rd(4'd4, v); check("R8 wrap high", v, 32'h0);

    // R2 halt
    wr(4'd1, 0);
    pulse(8'hFF, 5);
    rd(4'd3, v); check("R2 halted counter frozen", v, 32'h1);
    wr(4'd1, 1);
    pulse(8'hFF, 5);
    rd(4'd3, v); check("R2 resumed counter", v, 32'h6);

    // R10 names
    for (int k = 0; k < NCOND + 2; k++) begin
      wr(4'd8, k);
      rd(4'd9, v);
      check($sformatf("R10 name%0d lo", k), v, (k < NCOND) ? name_word(k, 0) : 0);
      rd(4'd10, v);
      check($sformatf("R10 name%0d hi", k), v, (k < NCOND) ? name_word(k, 1) : 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule